// File: doc/BRIEF.md
# Readout Interleave Sequencer

This block decides when a display leaves waveform mode and enters character-readout mode, so readout dots can be drawn in the dead time between sweeps. A rising edge on the A-sweep gate marks the end of a sweep. That edge enters readout mode and starts a holdoff countdown. The readout circuitry can also request readout mode at any time.

During a holdoff that follows a sweep, an active-low permit line tells the readout circuitry it may draw dots. The permit is withdrawn a programmable guard interval before holdoff ends, so drawn characters never overlap the triggering event.

The final blank output has two sources. In readout mode it follows the readout circuitry's own blank signal. Otherwise it is driven by chopped-vertical blanking and by blanking after a front-panel control change. A control-change pulse restarts holdoff with the full count and cancels any readout permit.

Holdoff length and guard length are cycle counts supplied on input ports. All four outputs are registered. Each responds on the clock edge that samples its causing input.

Top module: `readout_interleave_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it, the outputs read `ro_mode`=0, `ro_permit_n`=1, `holdoff`=0 and `blank_out`=1.
- R2: When `sweep_gate` is sampled high after being sampled low, `ro_mode` and `holdoff` are 1 from the next cycle. `holdoff` then stays 1 for exactly `hold_len` cycles.
- R3: In a holdoff started by a sweep end, `ro_permit_n` is 0 for the first `hold_len`−`guard_len` holdoff cycles. It is 1 for the last `guard_len` holdoff cycles. It is never 0 outside holdoff.
- R4: When `guard_len` is greater than or equal to `hold_len`, `ro_permit_n` stays 1 for the whole holdoff.
- R5: A sampled `ro_req`=1 makes `ro_mode`=1 in the next cycle. `ro_mode` stays 1 while holdoff runs or the request remains high.
- R6: `ro_mode` returns to 0 in the cycle after the last holdoff cycle, provided `ro_req` and a new sweep end are both absent.
- R7: In readout mode, `blank_out` equals `ro_blank` of the previous cycle, and `chop_blank` has no effect on it.
- R8: Outside readout mode, `blank_out` is 1 when `chop_blank` was 1 in the previous cycle, or while a holdoff started by `ctrl_chg` runs. Otherwise it is 0.
- R9: A `ctrl_chg` pulse reloads holdoff with the full `hold_len`, even in mid-holdoff. It forces `ro_permit_n` to 1 for the rest of that holdoff.
- R10: With `hold_len`=0, a sweep end gives no holdoff cycle and keeps `ro_permit_n`=1. `ro_mode` is 1 for a single cycle.
- R11: Holding `sweep_gate` high without a new rising edge does not restart holdoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_len | input | CNT_W | Holdoff length in cycles |
| guard_len | input | CNT_W | Guard interval in cycles before holdoff ends |
| sweep_gate | input | 1 | A-sweep gate; a rising edge marks the end of a sweep |
| ro_req | input | 1 | Readout request from the readout circuitry |
| ro_blank | input | 1 | Blank request from the readout circuitry |
| chop_blank | input | 1 | Blank request for chopped vertical transitions |
| ctrl_chg | input | 1 | One-cycle pulse on a front-panel control change |
| ro_mode | output | 1 | 1 selects readout mode for deflection and intensity |
| ro_permit_n | output | 1 | Active-low permission to draw readout dots |
| holdoff | output | 1 | Trigger holdoff active |
| blank_out | output | 1 | Final beam blanking |

## Verification
The bench goes after the guard edge: a comparison off by one would release the permit one cycle early or late and shift the low window away from `hold_len`−`guard_len` cycles. It holds `sweep_gate` high across several cycles. A design that detects the level rather than the edge would keep reloading holdoff and never end it. It pulses `ctrl_chg` in the middle of a sweep holdoff. A design that does not cancel the permit would let readout draw into a change interval, and one that does not reload the count would end holdoff early. It also covers a guard equal to the length, a zero length, and `chop_blank` during readout, where the wrong source in the blank mux would blank readout characters.

// File: rtl/roi_pkg.sv
package roi_pkg;

  // Event set sampled on one clock edge.
  typedef struct packed {
    logic sweep_end;  // rising edge of the sweep gate
    logic chg;        // front-panel change pulse
    logic req;        // readout request
  } roi_evt_t;

  // Source selected by the blank mux.
  typedef enum logic {
    BSRC_WAVE    = 1'b0,
    BSRC_READOUT = 1'b1
  } roi_bsrc_e;

endpackage

// File: rtl/roi_holdoff_timer.sv
module roi_holdoff_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic [CNT_W-1:0] guard,
  output logic             live_nxt,
  output logic             above_nxt,
  output logic             holdoff
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // Reload on a start event; otherwise count down to zero and stop.
  always_comb begin
    if (load)
      cnt_d = len;
    else if (cnt_q != ZERO)
      cnt_d = cnt_q - ONE;
    else
      cnt_d = ZERO;
  end

  assign live_nxt  = (cnt_d != ZERO);
  assign above_nxt = (cnt_d > guard);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= ZERO;
      holdoff <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      holdoff <= live_nxt;
    end
  end

endmodule

// File: rtl/roi_mode_ctrl.sv
module roi_mode_ctrl
  import roi_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  roi_evt_t evt,
  input  logic     live_nxt,
  input  logic     above_nxt,
  output logic     mode_nxt,
  output logic     chg_ho_nxt,
  output logic     ro_mode,
  output logic     ro_permit_n
);

  logic sweep_ho_q, sweep_ho_d;
  logic chg_ho_q;

  // Permit is only tied to a holdoff begun by a sweep end; a change pulse cancels it.
  assign sweep_ho_d = evt.sweep_end | (sweep_ho_q & ~evt.chg & live_nxt);
  assign chg_ho_nxt = evt.chg | (chg_ho_q & live_nxt);
  assign mode_nxt   = evt.sweep_end | evt.req | (ro_mode & live_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_ho_q  <= 1'b0;
      chg_ho_q    <= 1'b0;
      ro_mode     <= 1'b0;
      ro_permit_n <= 1'b1;
    end else begin
      sweep_ho_q  <= sweep_ho_d;
      chg_ho_q    <= chg_ho_nxt;
      ro_mode     <= mode_nxt;
      ro_permit_n <= ~(sweep_ho_d & above_nxt);
    end
  end

endmodule

// File: rtl/roi_blank_mux.sv
module roi_blank_mux
  import roi_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_nxt,
  input  logic chg_ho_nxt,
  input  logic ro_blank,
  input  logic chop_blank,
  output logic blank_out
);

  roi_bsrc_e sel;
  logic      blank_d;

  assign sel = mode_nxt ? BSRC_READOUT : BSRC_WAVE;

  always_comb begin
    unique case (sel)
      BSRC_READOUT: blank_d = ro_blank;
      default:      blank_d = chop_blank | chg_ho_nxt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) blank_out <= 1'b1;
    else     blank_out <= blank_d;
  end

endmodule

// File: rtl/readout_interleave_seq.sv
module readout_interleave_seq
  import roi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] hold_len,
  input  logic [CNT_W-1:0] guard_len,
  input  logic             sweep_gate,
  input  logic             ro_req,
  input  logic             ro_blank,
  input  logic             chop_blank,
  input  logic             ctrl_chg,
  output logic             ro_mode,
  output logic             ro_permit_n,
  output logic             holdoff,
  output logic             blank_out
);

  logic     sg_q;
  roi_evt_t evt;
  logic     live_nxt, above_nxt, mode_nxt, chg_ho_nxt;

  always_ff @(posedge clk) begin
    if (rst) sg_q <= 1'b0;
    else     sg_q <= sweep_gate;
  end

  assign evt.sweep_end = sweep_gate & ~sg_q;
  assign evt.chg       = ctrl_chg;
  assign evt.req       = ro_req;

  roi_holdoff_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load      (evt.sweep_end | evt.chg),
    .len       (hold_len),
    .guard     (guard_len),
    .live_nxt  (live_nxt),
    .above_nxt (above_nxt),
    .holdoff   (holdoff)
  );

  roi_mode_ctrl u_mode (
    .clk         (clk),
    .rst         (rst),
    .evt         (evt),
    .live_nxt    (live_nxt),
    .above_nxt   (above_nxt),
    .mode_nxt    (mode_nxt),
    .chg_ho_nxt  (chg_ho_nxt),
    .ro_mode     (ro_mode),
    .ro_permit_n (ro_permit_n)
  );

  roi_blank_mux u_blank (
    .clk        (clk),
    .rst        (rst),
    .mode_nxt   (mode_nxt),
    .chg_ho_nxt (chg_ho_nxt),
    .ro_blank   (ro_blank),
    .chop_blank (chop_blank),
    .blank_out  (blank_out)
  );

endmodule

// File: rtl/roi_checker.sv
module roi_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] hold_len,
  input logic             sweep_gate,
  input logic             ro_req,
  input logic             ro_blank,
  input logic             ctrl_chg,
  input logic             ro_mode,
  input logic             ro_permit_n,
  input logic             holdoff,
  input logic             blank_out
);

  assert_permit_in_holdoff_R3: assert property (@(posedge clk) disable iff (rst)
    !ro_permit_n |-> holdoff);

  assert_sweep_enters_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sweep_gate) |=> ro_mode);

  assert_req_enters_R5: assert property (@(posedge clk) disable iff (rst)
    ro_req |=> ro_mode);

  assert_ro_blank_follows_R7: assert property (@(posedge clk) disable iff (rst)
    ro_mode |-> (blank_out == $past(ro_blank)));

  assert_mode_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (!holdoff && !$past(ro_req) && !$past(sweep_gate)) |-> !ro_mode);

  assert_change_restarts_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_chg && hold_len != '0) |=> (holdoff && ro_permit_n));

endmodule

bind readout_interleave_seq roi_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hold_len    (hold_len),
  .sweep_gate  (sweep_gate),
  .ro_req      (ro_req),
  .ro_blank    (ro_blank),
  .ctrl_chg    (ctrl_chg),
  .ro_mode     (ro_mode),
  .ro_permit_n (ro_permit_n),
  .holdoff     (holdoff),
  .blank_out   (blank_out)
);

// File: tb/readout_interleave_seq_bench.sv
module readout_interleave_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int NVEC       = 21;

  // Row: {sweep_gate, ro_req, ro_blank, chop_blank, ctrl_chg, exp_mode, exp_permit_n, exp_holdoff, exp_blank}
  // Row inputs are driven for one cycle; the expected outputs are sampled one cycle later. hold_len=4, guard_len=1.
  localparam logic [8:0] VEC [NVEC] = '{
    9'b00000_0_1_0_0, // 0  idle (R8)
    9'b00010_0_1_0_1, // 1  chop blank outside readout (R8)
    9'b10000_1_0_1_0, // 2  sweep end: readout, holdoff, permit low (R2 R3)
    9'b10100_1_0_1_1, // 3  gate held high, ro_blank passes (R7 R11)
    9'b10010_1_0_1_0, // 4  chop ignored in readout (R7)
    9'b00000_1_1_1_0, // 5  guard cycle, permit released (R3)
    9'b00000_0_1_0_0, // 6  holdoff over, mode exits (R6)
    9'b01100_1_1_0_1, // 7  request enters readout (R5)
    9'b01000_1_1_0_0, // 8  request held (R5)
    9'b00000_0_1_0_0, // 9  request gone, exit (R6)
    9'b00001_0_1_1_1, // 10 change pulse starts holdoff, blank (R9 R8)
    9'b00000_0_1_1_1, // 11 change holdoff blanks (R8)
    9'b00000_0_1_1_1, // 12
    9'b10000_1_0_1_0, // 13 sweep end inside change holdoff (R2)
    9'b10000_1_0_1_0, // 14
    9'b10001_1_1_1_0, // 15 change mid-holdoff cancels permit (R9)
    9'b00000_1_1_1_0, // 16
    9'b00000_1_1_1_0, // 17
    9'b00000_1_1_1_0, // 18 full reloaded length (R9)
    9'b00000_0_1_0_0, // 19 holdoff over (R6)
    9'b00000_0_1_0_0  // 20
  };

  logic             clk = 1'b0;
  logic             rst;
  logic [CNT_W-1:0] hold_len, guard_len;
  logic             sweep_gate, ro_req, ro_blank, chop_blank, ctrl_chg;
  logic             ro_mode, ro_permit_n, holdoff, blank_out;

  int  n_checks = 0;
  int  n_bad    = 0;
  bit  done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  readout_interleave_seq #(.CNT_W(CNT_W)) u_readout_interleave_seq (
    .clk         (clk),
    .rst         (rst),
    .hold_len    (hold_len),
    .guard_len   (guard_len),
    .sweep_gate  (sweep_gate),
    .ro_req      (ro_req),
    .ro_blank    (ro_blank),
    .chop_blank  (chop_blank),
    .ctrl_chg    (ctrl_chg),
    .ro_mode     (ro_mode),
    .ro_permit_n (ro_permit_n),
    .holdoff     (holdoff),
    .blank_out   (blank_out)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(input string tag, input logic [3:0] exp);
    check({tag, " ro_mode"},     ro_mode,     exp[3]);
    check({tag, " ro_permit_n"}, ro_permit_n, exp[2]);
    check({tag, " holdoff"},     holdoff,     exp[1]);
    check({tag, " blank_out"},   blank_out,   exp[0]);
  endtask

  initial begin
    rst = 1'b1; hold_len = 8'd4; guard_len = 8'd1;
    {sweep_gate, ro_req, ro_blank, chop_blank, ctrl_chg} = '0;
    repeat (3) @(negedge clk);
    check_all("R1 reset", 4'b0101);
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      {sweep_gate, ro_req, ro_blank, chop_blank, ctrl_chg} = VEC[i][8:4];
      @(negedge clk);
      check_all($sformatf("table row %0d", i), VEC[i][3:0]);
    end
    {sweep_gate, ro_req, ro_blank, chop_blank, ctrl_chg} = '0;
    @(negedge clk);

    // R4: guard equal to length keeps the permit high
    guard_len  = 8'd4;
    sweep_gate = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R4 holdoff", holdoff, 1'b1);
      check("R4 permit held high", ro_permit_n, 1'b1);
    end
    @(negedge clk);
    check("R4 holdoff end", holdoff, 1'b0);
    sweep_gate = 1'b0; guard_len = 8'd1;
    repeat (2) @(negedge clk);

    // R10: zero length
    hold_len   = 8'd0;
    sweep_gate = 1'b1;
    @(negedge clk);
    check_all("R10 zero length", 4'b1100);
    @(negedge clk);
    check_all("R10 single cycle", 4'b0100);
    sweep_gate = 1'b0; hold_len = 8'd4;
    repeat (2) @(negedge clk);

    // R1: reset in mid-holdoff
    sweep_gate = 1'b1;
    @(negedge clk);
    check("R1 pre-reset holdoff", holdoff, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check_all("R1 mid-holdoff reset", 4'b0101);
    rst = 1'b0; sweep_gate = 1'b0;
    @(negedge clk);
    check_all("R1 after reset", 4'b0100);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: run did not complete got=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule